// File: doc/BRIEF.md
# Receive Squelch Data-Valid Qualifier

This block sits behind the slicer of a coaxial receive path and decides whether the sliced bit stream carries real traffic or only noise. It runs on an oversampling clock, with one tick standing for 10 ns by default. It takes three inputs: the sliced receive bit, a level-ok flag from an external averaging comparator, and a synchronous reset. Both asynchronous inputs pass through a two-stage synchroniser before any other logic sees them.

A narrow-pulse filter removes any excursion shorter than the minimum pulse width. Each excursion that survives counts as a qualified transition and restarts a transition-period timer. Data is declared valid only while three things hold at once: the level flag is set, qualified transitions keep arriving, and no two of them are further apart than the gap limit. The line-driver enable follows the valid decision. The gated receive output carries the filtered level while valid and sits at the idle zero state at every other time. Once transitions stop, the timer runs out and the driver drops to idle.

Top module: `rxq_squelch`

## Requirements
- R1: While reset is held and on the first edge after it, `data_valid_o`, `drv_en_o` and `rx_data_o` are all 0.
- R2: A run of fewer than MIN_PULSE (default 3) consecutive samples that differs from the filtered level is dropped as noise. It does not change the filtered level and it does not restart the transition timer. A run of at least MIN_PULSE samples is accepted as a transition.
- R3: The level flag is high, the filtered level has been quiet, and an accepted run has its first sample on clock edge S. Then `data_valid_o` rises on edge S+MIN_PULSE+3.
- R4: Accepted transitions that are at most MAX_GAP (default 20) edges apart keep `data_valid_o` high without a break. A spacing of MAX_GAP+1 edges drops it for exactly one cycle.
- R5: When the last accepted run has its first sample on edge S, `data_valid_o` falls on edge S+MIN_PULSE+MAX_GAP+3 and stays low until a new accepted transition arrives.
- R6: When the level flag is sampled low on edge L, `data_valid_o` is low after edge L+2, whatever the transitions do. When the flag is sampled high again, validity returns two edges later if the timer is still running.
- R7: `drv_en_o` equals `data_valid_o` on every cycle.
- R8: `rx_data_o` is 0 (the idle state) on every cycle in which `data_valid_o` is 0. While valid, it carries the accepted level, which it takes on edge S+MIN_PULSE+2 for a run whose first sample is on edge S.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_bit_i | input | 1 | Sliced receive bit, asynchronous |
| level_ok_i | input | 1 | Averaged level check result, asynchronous, 1 = pass |
| data_valid_o | output | 1 | Receive data valid |
| drv_en_o | output | 1 | Receive line-driver enable |
| rx_data_o | output | 1 | Gated receive data, 0 when idle |

## Verification
The checker assumes nothing about the shape of the receive stream. It does assume that both asynchronous inputs are stable around the sampling edge, so that the synchroniser output is a clean delayed copy and the latencies in R3, R5, R6 and R8 are exact. The bench meets this by changing inputs only on the falling clock edge. It builds its stimulus from whole runs of alternating polarity, so that every sample belongs to a run of known length. Its expected values are derived from run start edges, accepted-run rules and the sampled level flag.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

    localparam int unsigned DEF_MIN_PULSE   = 3;
    localparam int unsigned DEF_MAX_GAP     = 20;
    localparam int unsigned DEF_SYNC_STAGES = 2;

    typedef struct packed {
        logic rx;
        logic lvl;
    } line_t;

    typedef struct packed {
        logic level;
        logic edge_seen;
    } filt_t;

    typedef struct packed {
        logic valid;
        logic drv;
        logic data;
    } rx_out_t;

    typedef enum logic [0:0] {
        OUT_IDLE  = 1'b0,
        OUT_DRIVE = 1'b1
    } out_state_e;

    function automatic int unsigned cnt_w(int unsigned n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/rxq_sync.sv
module rxq_sync #(
    parameter int unsigned WIDTH  = 2,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] stg [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stg[g] <= '0;
                else     stg[g] <= d_i;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stg[g] <= '0;
                else     stg[g] <= stg[g-1];
            end
        end
    end

    assign q_o = stg[STAGES-1];
endmodule

// File: rtl/rxq_pulse_filter.sv
module rxq_pulse_filter
    import rxq_pkg::*;
#(
    parameter int unsigned MIN_PULSE = DEF_MIN_PULSE
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  din_i,
    output filt_t filt_o
);
    localparam int unsigned CW = cnt_w(MIN_PULSE);
    localparam logic [CW-1:0] LAST = CW'(MIN_PULSE - 1);

    logic [CW-1:0] run_q;
    logic          level_q;
    logic          edge_q;
    logic          differs;

    assign differs = (din_i != level_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q   <= '0;
            level_q <= 1'b0;
            edge_q  <= 1'b0;
        end else begin
            edge_q <= 1'b0;
            if (!differs) begin
                run_q <= '0;
            end else if (run_q == LAST) begin
                run_q   <= '0;
                level_q <= din_i;
                edge_q  <= 1'b1;
            end else begin
                run_q <= run_q + 1'b1;
            end
        end
    end

    assign filt_o.level     = level_q;
    assign filt_o.edge_seen = edge_q;
endmodule

// File: rtl/rxq_gap_timer.sv
module rxq_gap_timer
    import rxq_pkg::*;
#(
    parameter int unsigned MAX_GAP = DEF_MAX_GAP
) (
    input  logic clk,
    input  logic rst,
    input  logic edge_i,
    output logic alive_o
);
    localparam int unsigned GW = cnt_w(MAX_GAP);
    localparam logic [GW-1:0] GAP_END = GW'(MAX_GAP - 1);

    logic [GW-1:0] gap_q;
    logic          alive_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            gap_q   <= '0;
            alive_q <= 1'b0;
        end else if (edge_i) begin
            gap_q   <= '0;
            alive_q <= 1'b1;
        end else if (alive_q) begin
            if (gap_q == GAP_END) begin
                alive_q <= 1'b0;
                gap_q   <= '0;
            end else begin
                gap_q <= gap_q + 1'b1;
            end
        end
    end

    assign alive_o = alive_q;
endmodule

// File: rtl/rxq_out_ctrl.sv
module rxq_out_ctrl
    import rxq_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    alive_i,
    input  logic    lvl_i,
    input  logic    level_i,
    output rx_out_t out_o
);
    out_state_e state_q, state_d;
    logic       qual;
    logic       valid_q;
    logic       data_q;

    assign qual = alive_i & lvl_i;

    always_comb begin
        state_d = state_q;
        case (state_q)
            OUT_IDLE:  if (qual)  state_d = OUT_DRIVE;
            OUT_DRIVE: if (!qual) state_d = OUT_IDLE;
            default:              state_d = OUT_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= OUT_IDLE;
            valid_q <= 1'b0;
            data_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            valid_q <= qual;
            data_q  <= qual ? level_i : 1'b0;
        end
    end

    assign out_o.valid = valid_q;
    assign out_o.drv   = (state_q == OUT_DRIVE);
    assign out_o.data  = data_q;
endmodule

// File: rtl/rxq_squelch.sv
module rxq_squelch
    import rxq_pkg::*;
#(
    parameter int unsigned MIN_PULSE   = DEF_MIN_PULSE,
    parameter int unsigned MAX_GAP     = DEF_MAX_GAP,
    parameter int unsigned SYNC_STAGES = DEF_SYNC_STAGES
) (
    input  logic clk,
    input  logic rst,
    input  logic rx_bit_i,
    input  logic level_ok_i,
    output logic data_valid_o,
    output logic drv_en_o,
    output logic rx_data_o
);
    line_t   line_raw, line_s;
    filt_t   filt;
    rx_out_t outs;
    logic    lvl_s;
    logic    flt_level;
    logic    flt_edge;
    logic    alive;

    assign line_raw.rx  = rx_bit_i;
    assign line_raw.lvl = level_ok_i;

    rxq_sync #(.WIDTH($bits(line_t)), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (line_raw),
        .q_o (line_s)
    );

    assign lvl_s = line_s.lvl;

    rxq_pulse_filter #(.MIN_PULSE(MIN_PULSE)) u_filt (
        .clk    (clk),
        .rst    (rst),
        .din_i  (line_s.rx),
        .filt_o (filt)
    );

    assign flt_level = filt.level;
    assign flt_edge  = filt.edge_seen;

    rxq_gap_timer #(.MAX_GAP(MAX_GAP)) u_gap (
        .clk     (clk),
        .rst     (rst),
        .edge_i  (flt_edge),
        .alive_o (alive)
    );

    rxq_out_ctrl u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .alive_i (alive),
        .lvl_i   (lvl_s),
        .level_i (flt_level),
        .out_o   (outs)
    );

    assign data_valid_o = outs.valid;
    assign drv_en_o     = outs.drv;
    assign rx_data_o    = outs.data;
endmodule

// File: rtl/rxq_squelch_chk.sv
module rxq_squelch_chk
    import rxq_pkg::*;
#(
    parameter int unsigned MAX_GAP = DEF_MAX_GAP
) (
    input logic clk,
    input logic rst,
    input logic valid,
    input logic drv,
    input logic data,
    input logic lvl_s,
    input logic flt,
    input logic fedge
);
    localparam int unsigned QW = cnt_w(MAX_GAP + 1);
    localparam logic [QW-1:0] QLIM = QW'(MAX_GAP + 1);

    logic [QW-1:0] quiet_q;

    always_ff @(posedge clk) begin
        if (rst)                  quiet_q <= QLIM;
        else if (fedge)           quiet_q <= '0;
        else if (quiet_q != QLIM) quiet_q <= quiet_q + 1'b1;
    end

    AST_DRV_TRACKS_VALID: assert property (@(posedge clk) disable iff (rst)
        drv == valid); // R7
    AST_IDLE_DATA_ZERO: assert property (@(posedge clk) disable iff (rst)
        !valid |-> (data == 1'b0)); // R8
    AST_DATA_FOLLOWS_FILTER: assert property (@(posedge clk) disable iff (rst)
        valid |-> (data == $past(flt))); // R8
    AST_VALID_NEEDS_LEVEL: assert property (@(posedge clk) disable iff (rst)
        valid |-> $past(lvl_s)); // R6
    AST_SILENCE_DROPS: assert property (@(posedge clk) disable iff (rst)
        (quiet_q > MAX_GAP) |-> !valid); // R5
    AST_FLT_MOVES_ON_EDGE: assert property (@(posedge clk) disable iff (rst)
        !fedge |-> $stable(flt)); // R2
endmodule

bind rxq_squelch rxq_squelch_chk #(.MAX_GAP(MAX_GAP)) u_chk (
    .clk   (clk),
    .rst   (rst),
    .valid (data_valid_o),
    .drv   (drv_en_o),
    .data  (rx_data_o),
    .lvl_s (lvl_s),
    .flt   (flt_level),
    .fedge (flt_edge)
);

// File: tb/sim_rxq_squelch.sv
module sim_rxq_squelch;
    localparam int MIN_PULSE = 3;
    localparam int MAX_GAP   = 20;
    localparam int HIST      = 16384;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic rx_bit = 1'b0;
    logic level_ok = 1'b0;
    logic data_valid, drv_en, rx_data;

    always #10 clk = ~clk;

    rxq_squelch #(.MIN_PULSE(MIN_PULSE), .MAX_GAP(MAX_GAP)) u0 (
        .clk          (clk),
        .rst          (rst),
        .rx_bit_i     (rx_bit),
        .level_ok_i   (level_ok),
        .data_valid_o (data_valid),
        .drv_en_o     (drv_en),
        .rx_data_o    (rx_data)
    );

    typedef struct {
        int    k;
        bit    v;
        bit    d;
        string tag;
    } exp_t;

    exp_t exq[$];
    int   tog_e[$];
    bit   tog_v[$];
    bit   lh [HIST];
    int   cyc = 0;
    int   total = 0;
    int   bad = 0;
    bit   cur_flt = 1'b0;
    bit   drv_v = 1'b0;
    bit   done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic bit m_valid(int k);
        for (int i = tog_e.size() - 1; i >= 0; i--) begin
            if (tog_e[i] <= k - 2)
                return (k <= tog_e[i] + 1 + MAX_GAP) && lh[k-2];
        end
        return 1'b0;
    endfunction

    function automatic bit m_level(int e);
        for (int i = tog_e.size() - 1; i >= 0; i--)
            if (tog_e[i] <= e) return tog_v[i];
        return 1'b0;
    endfunction

    // flip=1: a new run of the opposite polarity; flip=0: extend the current run
    task automatic seg(bit flip, bit l, int len, string tag);
        int   s;
        exp_t r;
        if (flip) drv_v = ~drv_v;
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            if (i == 0) begin
                s = cyc + 1;
                for (int j = 0; j < len; j++) if (s + j < HIST) lh[s+j] = l;
                if (flip && drv_v != cur_flt && len >= MIN_PULSE) begin
                    tog_e.push_back(s + 1 + MIN_PULSE);
                    tog_v.push_back(drv_v);
                    cur_flt = drv_v;
                end
                for (int j = 0; j < len; j++) begin
                    r.k   = s + j;
                    r.v   = m_valid(s + j);
                    r.d   = r.v ? m_level(s + j - 1) : 1'b0;
                    r.tag = tag;
                    exq.push_back(r);
                end
            end
            rx_bit   = drv_v;
            level_ok = l;
        end
    endtask

    task automatic check(bit ok, string req, string what, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s at cycle %0d: actual=%0d expected=%0d", req, what, cyc, act, exp);
        end
    endtask

    // monitor: pops expected items as the design produces each cycle
    always @(negedge clk) begin
        if (!rst && !done) begin
            while (exq.size() > 0 && exq[0].k < cyc) begin
                check(1'b0, exq[0].tag, "missed item", exq[0].k, cyc);
                void'(exq.pop_front());
            end
            if (exq.size() > 0 && exq[0].k == cyc) begin
                check(data_valid == exq[0].v, exq[0].tag, "data_valid", data_valid, exq[0].v);
                check(drv_en == exq[0].v, "R7", "drv_en", drv_en, exq[0].v);
                check(rx_data == exq[0].d, "R8", "rx_data", rx_data, exq[0].d);
                void'(exq.pop_front());
            end
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        check(data_valid == 1'b0, "R1", "valid in reset", data_valid, 0);
        check(drv_en == 1'b0, "R1", "drv_en in reset", drv_en, 0);
        check(rx_data == 1'b0, "R1", "rx_data in reset", rx_data, 0);
        rst = 1'b0;
        @(negedge clk);
        check(data_valid == 1'b0 && drv_en == 1'b0 && rx_data == 1'b0, "R1",
              "outputs after reset", {data_valid, drv_en, rx_data}, 0);

        seg(1'b0, 1'b1, 10, "R1");
        // narrow pulses only: never valid
        seg(1'b1, 1'b1, 1, "R2");
        seg(1'b1, 1'b1, 6, "R2");
        seg(1'b1, 1'b1, 2, "R2");
        seg(1'b1, 1'b1, 30, "R2");
        // exactly MIN_PULSE wide: accepted, rise then fall
        seg(1'b1, 1'b1, 3, "R3");
        seg(1'b1, 1'b1, 40, "R5");
        // half-bit and full-bit runs
        for (int n = 0; n < 40; n++) seg(1'b1, 1'b1, (n % 3 == 0) ? 10 : 5, "R3");
        // spacing at the limit and one past it
        for (int n = 0; n < 4; n++) seg(1'b1, 1'b1, MAX_GAP, "R4");
        for (int n = 0; n < 3; n++) seg(1'b1, 1'b1, MAX_GAP + 1, "R4");
        // narrow pulse after silence does not restart the timer
        seg(1'b1, 1'b1, 18, "R2");
        seg(1'b1, 1'b1, 2, "R2");
        seg(1'b1, 1'b1, 30, "R2");
        // level flag drops mid-stream and returns
        for (int n = 0; n < 12; n++) seg(1'b1, (n < 4 || n > 7), 5, "R6");
        seg(1'b0, 1'b1, 40, "R5");
        // mixed pattern
        for (int n = 0; n < 200; n++)
            seg(1'b1, ($urandom_range(9) != 0), 1 + $urandom_range(24), "R4");
        seg(1'b1, 1'b1, 50, "R5");
        seg(1'b0, 1'b1, 10, "R5");

        repeat (3) @(negedge clk);
        check(exq.size() == 0, "R5", "queue drained", exq.size(), 0);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog expired: actual=%0d expected=%0d", cyc, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule